// File: doc/BRIEF.md
# PLL Clock Bring-up Sequencer

This block brings a clock-multiplying PLL into service from a single start request. The caller chooses the reference source (an external crystal or the host bus clock) and may supply the reference frequency in whole MHz. When no frequency is supplied, 66 MHz is assumed. The block checks that the frequency is usable and finds the largest multiplier that keeps the PLL output at or below 266 MHz. It packs that multiplier, a charge-pump range bit, the reference-select bit and a mandatory reserved bit into a 32-bit configuration word.

The word is then written to one configuration register address through a plain valid/address/data write strobe, in three steps. The first write selects the reference with the output bypass on and both engine clocks still on the bus clock. After a lock wait, whose length is a cycle-count parameter (about 10 ms at the default), the second write clears the bypass. The third write moves the public-key and packet engine clocks onto the PLL. A one-cycle done pulse follows. The block then holds the resulting public-key engine clock frequency in Hz, which is deliberately rounded upward, for whatever logic paces reads of the random-number source. The multiplier comes from a small iterative subtractor, not a combinational divider.

Top module: `pll_bringup_seq`

## Requirements
- R1: A start whose effective frequency lies outside 20..100 MHz inclusive sets `err` one cycle later. It produces no write and no done pulse. `err` holds until the next accepted start clears it.
- R2: When `freq_given` is low at start, the effective frequency is 66 MHz and `freq_mhz` is ignored.
- R3: With m = floor(266 / f), bits 13:11 of every written word hold m/2 - 1, using integer halving. Codes 0..5 mean multipliers 2..12.
- R4: Bit 16 of every written word is 1 when m > 8 and 0 when m <= 8.
- R5: Bit 10 of every written word is 1. Bit 0 equals `use_ext_ref` as it was at the accepted start: 1 for the external reference, 0 for the bus clock.
- R6: An accepted start yields exactly three writes, all to address `CFG_ADDR`, in this order: base | bit 1 (bypass); base; base | bit 3 | bit 4 (both engines on the PLL). Bits 1, 3 and 4 are 0 in the base word.
- R7: The second write comes exactly LOCK_CYCLES + 1 clock cycles after the first, and the third comes in the cycle directly after the second.
- R8: `done` is high for exactly one cycle, the cycle after the third write. From that cycle on, `pk_clk_hz` = 500000 × (f + 1) × m and holds until the next sequence.
- R9: A start raised while `busy` is high is ignored: the running sequence keeps its inputs and its three writes.
- R10: During and after reset, `wr_valid`, `busy`, `done` and `err` are 0 and `pk_clk_hz` is 0. Reset asserted mid-sequence stops all writes at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a bring-up sequence (taken only when idle) |
| use_ext_ref | input | 1 | 1 selects the external crystal reference, 0 the bus clock |
| freq_given | input | 1 | 1 means `freq_mhz` is valid, 0 selects 66 MHz |
| freq_mhz | input | 8 | Reference frequency in MHz |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Write address, always `CFG_ADDR` while valid |
| wr_data | output | 32 | Configuration word being written |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the third write |
| err | output | 1 | Last start was rejected for its frequency |
| pk_clk_hz | output | 32 | Public-key engine clock frequency in Hz |

## Verification
A wrong latched frequency, reference choice or quotient shows in the first write's multiplier, charge-pump or reference bits, within about fifteen cycles of start. A lock-wait counter that is off by any amount moves the second write away from its exact slot of LOCK_CYCLES + 1 cycles after the first. A state machine that skips or repeats a step shows as a missing, duplicated or reordered bypass or engine-switch bit, or as a done pulse that does not directly follow the third write. The frequency table covers both ends of the range, both sides of the charge-pump threshold, the odd-quotient rounding and the default frequency. Separate tests cover rejected values, a start raised while busy and reset during the lock wait.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVIDE,
    ST_WR_BYPASS,
    ST_LOCK_WAIT,
    ST_WR_REF,
    ST_WR_SWITCH,
    ST_FINISH
  } seq_state_t;

  localparam int CFG_W       = 32;
  localparam int BIT_REF_EXT = 0;
  localparam int BIT_BYPASS  = 1;
  localparam int BIT_PK_PLL  = 3;
  localparam int BIT_PE_PLL  = 4;
  localparam int BIT_RSVD    = 10;
  localparam int BIT_MULT_LO = 11;
  localparam int MULT_W      = 3;
  localparam int BIT_CP      = 16;
  localparam int CP_LIMIT    = 8;
  localparam int HZ_PER_HALF = 500000;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/pll_mult_div.sv
module pll_mult_div #(
  parameter int DIVIDEND = 266,
  parameter int DIV_W    = 8,
  parameter int Q_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] divisor,
  output logic [Q_W-1:0]   quot,
  output logic             fin
);

  localparam int REM_W = $clog2(DIVIDEND + 1);

  logic [REM_W-1:0] rem_q, rem_d;
  logic [Q_W-1:0]   q_q, q_d;
  logic             act_q, act_d;
  logic             fin_q, fin_d;
  logic [REM_W-1:0] div_ext;

  assign div_ext = REM_W'(divisor);

  always_comb begin
    rem_d = rem_q;
    q_d   = q_q;
    act_d = act_q;
    fin_d = 1'b0;
    if (load) begin
      rem_d = REM_W'(DIVIDEND);
      q_d   = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (rem_q >= div_ext) begin
        rem_d = rem_q - div_ext;
        q_d   = q_q + 1'b1;
      end else begin
        act_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      q_q   <= q_d;
      act_q <= act_d;
      fin_q <= fin_d;
    end
  end

  assign quot = q_q;
  assign fin  = fin_q;

endmodule

// File: rtl/pll_cfg_encode.sv
module pll_cfg_encode
  import pll_seq_pkg::*;
#(
  parameter int FREQ_W = 8,
  parameter int Q_W    = 4
) (
  input  logic              use_ext,
  input  logic [Q_W-1:0]    mult,
  input  logic [FREQ_W-1:0] freq,
  output logic [CFG_W-1:0]  base_word,
  output logic [31:0]       pk_hz
);

  logic [Q_W-1:0] half_m;

  always_comb begin
    half_m    = (mult >> 1) - 1'b1;
    base_word = '0;
    base_word[BIT_RSVD]    = 1'b1;
    base_word[BIT_REF_EXT] = use_ext;
    base_word[BIT_MULT_LO +: MULT_W] = MULT_W'(half_m);
    base_word[BIT_CP]      = (mult > Q_W'(CP_LIMIT));
  end

  assign pk_hz = (32'(freq) + 32'd1) * 32'(mult) * 32'(HZ_PER_HALF);

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CNT_W'(LOCK_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CFG_ADDR    = 8'h40,
  parameter int LOCK_CYCLES = 2500000,
  parameter int DEFAULT_MHZ = 66,
  parameter int FREQ_MIN    = 20,
  parameter int FREQ_MAX    = 100,
  parameter int FCK_MAX     = 266
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_ext_ref,
  input  logic              freq_given,
  input  logic [7:0]        freq_mhz,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       pk_clk_hz
);

  localparam int FREQ_W = 8;
  localparam int Q_W    = $clog2(FCK_MAX / FREQ_MIN + 1);

  logic              rst_n_s;
  seq_state_t        state_q, state_d;
  logic [FREQ_W-1:0] freq_q, freq_d;
  logic              ext_q, ext_d;
  logic [Q_W-1:0]    m_q, m_d;
  logic              err_q, err_d;
  logic [31:0]       hz_q, hz_d;
  logic [FREQ_W-1:0] eff_freq;
  logic              in_range;
  logic              div_load, div_fin;
  logic [Q_W-1:0]    div_quot;
  logic              tmr_load, tmr_exp;
  logic [CFG_W-1:0]  base_word;
  logic [31:0]       calc_hz;

  pll_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pll_mult_div #(
    .DIVIDEND (FCK_MAX),
    .DIV_W    (FREQ_W),
    .Q_W      (Q_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (div_load),
    .divisor (freq_q),
    .quot    (div_quot),
    .fin     (div_fin)
  );

  pll_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  pll_cfg_encode #(
    .FREQ_W (FREQ_W),
    .Q_W    (Q_W)
  ) u_enc (
    .use_ext   (ext_q),
    .mult      (m_q),
    .freq      (freq_q),
    .base_word (base_word),
    .pk_hz     (calc_hz)
  );

  assign eff_freq = freq_given ? freq_mhz : FREQ_W'(DEFAULT_MHZ);
  assign in_range = (eff_freq >= FREQ_W'(FREQ_MIN)) && (eff_freq <= FREQ_W'(FREQ_MAX));

  // Next-state process
  always_comb begin
    state_d  = state_q;
    freq_d   = freq_q;
    ext_d    = ext_q;
    m_d      = m_q;
    err_d    = err_q;
    hz_d     = hz_q;
    div_load = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (in_range) begin
            err_d    = 1'b0;
            freq_d   = eff_freq;
            ext_d    = use_ext_ref;
            div_load = 1'b1;
            state_d  = ST_DIVIDE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_DIVIDE: begin
        if (div_fin) begin
          m_d     = div_quot;
          state_d = ST_WR_BYPASS;
        end
      end
      ST_WR_BYPASS: begin
        tmr_load = 1'b1;
        state_d  = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        if (tmr_exp) begin
          state_d = ST_WR_REF;
        end
      end
      ST_WR_REF: begin
        state_d = ST_WR_SWITCH;
      end
      ST_WR_SWITCH: begin
        hz_d    = calc_hz;
        state_d = ST_FINISH;
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      freq_q  <= '0;
      ext_q   <= 1'b0;
      m_q     <= '0;
      err_q   <= 1'b0;
      hz_q    <= '0;
    end else begin
      state_q <= state_d;
      freq_q  <= freq_d;
      ext_q   <= ext_d;
      m_q     <= m_d;
      err_q   <= err_d;
      hz_q    <= hz_d;
    end
  end

  // Write port decode
  always_comb begin
    wr_valid = 1'b0;
    wr_data  = '0;
    unique case (state_q)
      ST_WR_BYPASS: begin
        wr_valid = 1'b1;
        wr_data  = base_word;
        wr_data[BIT_BYPASS] = 1'b1;
      end
      ST_WR_REF: begin
        wr_valid = 1'b1;
        wr_data  = base_word;
      end
      ST_WR_SWITCH: begin
        wr_valid = 1'b1;
        wr_data  = base_word;
        wr_data[BIT_PK_PLL] = 1'b1;
        wr_data[BIT_PE_PLL] = 1'b1;
      end
      default: begin
        wr_valid = 1'b0;
      end
    endcase
  end

  assign wr_addr   = wr_valid ? ADDR_W'(CFG_ADDR) : '0;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FINISH);
  assign err       = err_q;
  assign pk_clk_hz = hz_q;

endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
  parameter int ADDR_W   = 8,
  parameter int CFG_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              busy,
  input logic              done,
  input logic              err
);

  p_wr_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  p_wr_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr == ADDR_W'(CFG_ADDR)));

  p_rsvd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[10]);

  p_cp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[16]) |-> (wr_data[13:11] >= 3'd3));

  p_err_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_valid && !done));

  p_switch_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_data[1] && !wr_data[3]) |=> (wr_valid && wr_data[3] && wr_data[4]));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_valid) && $past(wr_data[3])));

endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(
  .ADDR_W   (ADDR_W),
  .CFG_ADDR (CFG_ADDR)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb_top;

  localparam int ADDR_W   = 8;
  localparam int CFG_ADDR = 8'h40;
  localparam int LOCK     = 5;
  localparam int WINDOW   = 60;

  typedef struct packed {
    logic       ext;
    logic       given;
    logic [7:0] freq;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 8'd20},
    '{1'b0, 1'b1, 8'd29},
    '{1'b1, 1'b1, 8'd30},
    '{1'b1, 1'b0, 8'd0},
    '{1'b0, 1'b1, 8'd67},
    '{1'b1, 1'b1, 8'd100},
    '{1'b0, 1'b1, 8'd38},
    '{1'b1, 1'b1, 8'd53},
    '{1'b0, 1'b1, 8'd19},
    '{1'b1, 1'b1, 8'd101},
    '{1'b0, 1'b1, 8'd0},
    '{1'b0, 1'b0, 8'd200}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              use_ext_ref;
  logic              freq_given;
  logic [7:0]        freq_mhz;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              busy;
  logic              done;
  logic              err;
  logic [31:0]       pk_clk_hz;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pll_bringup_seq #(
    .ADDR_W      (ADDR_W),
    .CFG_ADDR    (CFG_ADDR),
    .LOCK_CYCLES (LOCK)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .use_ext_ref (use_ext_ref),
    .freq_given  (freq_given),
    .freq_mhz    (freq_mhz),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .pk_clk_hz   (pk_clk_hz)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 100000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected < 100000", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic ext, input logic given, input logic [7:0] f, input bit poke);
    int eff, m, exp_base, exp_hz, nwr, done_cyc, hz_at;
    bit exp_err;
    int wd [3];
    int wc [3];
    eff      = given ? int'(f) : 66;
    exp_err  = (eff < 20) || (eff > 100);
    m        = exp_err ? 2 : 266 / eff;
    exp_base = (1 << 10) | int'(ext) | (((m / 2) - 1) << 11) | ((m > 8) ? (1 << 16) : 0);
    exp_hz   = 500000 * (eff + 1) * m;
    nwr      = 0;
    done_cyc = -1;
    hz_at    = 0;
    wd       = '{0, 0, 0};
    wc       = '{0, 0, 0};
    @(negedge clk);
    use_ext_ref = ext;
    freq_given  = given;
    freq_mhz    = f;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < WINDOW; c++) begin
      if (c == 0) check(err == exp_err, exp_err ? "R1 err raised" : "R1 err clear", err, exp_err);
      if (wr_valid) begin
        if (nwr < 3) begin
          wd[nwr] = int'(wr_data);
          wc[nwr] = c;
        end
        nwr = nwr + 1;
        check(wr_addr == ADDR_W'(CFG_ADDR), "R6 address", wr_addr, CFG_ADDR);
      end
      if (done && done_cyc < 0) begin
        done_cyc = c;
        hz_at    = int'(pk_clk_hz);
      end
      if (poke && c == 3) begin
        check(busy == 1'b1, "R9 busy during run", busy, 1);
        start       = 1'b1;
        freq_mhz    = 8'd20;
        freq_given  = 1'b1;
        use_ext_ref = ~ext;
      end
      if (poke && c == 4) start = 1'b0;
      @(negedge clk);
    end
    if (exp_err) begin
      check(nwr == 0, "R1 no writes on reject", nwr, 0);
      check(done_cyc < 0, "R1 no done on reject", done_cyc, -1);
    end else begin
      check(nwr == 3, poke ? "R9 three writes despite start" : "R6 write count", nwr, 3);
      check(wd[0] == (exp_base | 2), given ? "R6 bypass word" : "R2 default bypass word", wd[0], exp_base | 2);
      check(wd[1] == exp_base, "R6 lock word", wd[1], exp_base);
      check(wd[2] == (exp_base | 24), "R6 switch word", wd[2], exp_base | 24);
      check(((wd[0] >> 11) & 7) == ((m / 2) - 1), "R3 multiplier field", (wd[0] >> 11) & 7, (m / 2) - 1);
      check(((wd[1] >> 16) & 1) == ((m > 8) ? 1 : 0), "R4 charge pump bit", (wd[1] >> 16) & 1, (m > 8) ? 1 : 0);
      check(((wd[2] >> 10) & 1) == 1 && (wd[2] & 1) == int'(ext), "R5 reserved and reference bits",
            wd[2] & 32'h401, 32'h400 | int'(ext));
      check(wc[1] - wc[0] == LOCK + 1, "R7 lock gap", wc[1] - wc[0], LOCK + 1);
      check(wc[2] - wc[1] == 1, "R7 switch follows", wc[2] - wc[1], 1);
      check(done_cyc == wc[2] + 1, "R8 done timing", done_cyc, wc[2] + 1);
      check(hz_at == exp_hz, "R8 engine clock Hz", hz_at, exp_hz);
      check(pk_clk_hz == 32'(exp_hz), "R8 Hz held", pk_clk_hz, exp_hz);
    end
    check(busy == 1'b0, "R6 idle after sequence", busy, 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    start       = 1'b0;
    use_ext_ref = 1'b0;
    freq_given  = 1'b0;
    freq_mhz    = 8'd0;
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R10 reset wr_valid", wr_valid, 0);
    check(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {busy, done}, 0);
    check(err == 1'b0, "R10 reset err", err, 0);
    check(pk_clk_hz == 32'd0, "R10 reset pk_clk_hz", pk_clk_hz, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_case(VEC[i].ext, VEC[i].given, VEC[i].freq, 1'b0);
    end

    run_case(1'b1, 1'b1, 8'd66, 1'b0);
    check(err == 1'b0, "R1 err cleared by accepted start", err, 0);

    run_case(1'b0, 1'b1, 8'd44, 1'b1);

    @(negedge clk);
    use_ext_ref = 1'b1;
    freq_given  = 1'b1;
    freq_mhz    = 8'd50;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 1'b0 && wr_valid == 1'b0, "R10 mid-run reset stops", {busy, wr_valid}, 0);
    check(pk_clk_hz == 32'd0, "R10 mid-run reset clears Hz", pk_clk_hz, 0);
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (wr_valid) seen = seen + 1;
      end
      check(seen == 0, "R10 no writes in reset", seen, 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_case(1'b0, 1'b1, 8'd25, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule